// File: doc/BRIEF.md
# Gated Frequency and Period Counter

This block measures an external signal in one of two ways with one shared saturating counter. In frequency mode it opens a gate on the first millisecond tick after a start request, keeps it open for a selectable number of ticks, and counts the rising edges of the high-speed input seen inside that window. In period mode it waits for a rising edge on a separate low-frequency input, then counts system-clock cycles until the next rising edge of that input. The result is the length of one input period in clock cycles.

Both signal inputs are asynchronous and pass through a synchronizer and a rising-edge detector. The mode and gate code are captured when a start request is accepted. During a run the block reports busy. At the end it copies the count into a holding register, raises done and drops busy. If the count would go past the all-ones value it stays there and raises a sticky overflow flag. The next accepted start clears that flag.

Top module: `gated_freq_counter`

## Requirements
- R1: While reset is active and right after it is released, `busy_o`, `done_o` and `ovf_o` are 0 and `result_o` is 0.
- R2: In frequency mode (`mode_i` = 0) the gate opens on the first `tick_i` pulse after the accepted start and closes on the N-th `tick_i` pulse after that. The result equals the number of rising edges of `sig_i` that fall between those two ticks.
- R3: The gate code captured at start selects N: 00 gives 1 tick, 01 gives 4, 10 gives 8 and 11 gives 32.
- R4: In period mode (`mode_i` = 1) counting begins at the first rising edge of `lf_sig_i` after start and ends at the next one. The result equals the distance between the two edges in clock cycles.
- R5: Frequency mode ignores `lf_sig_i` and period mode ignores `sig_i`.
- R6: A count that would exceed 2^CNT_W − 1 stays at 2^CNT_W − 1 and sets `ovf_o`. A count of exactly 2^CNT_W − 1 does not set it. `ovf_o` stays set until the next accepted start clears it.
- R7: `busy_o` is 1 from the cycle after an accepted start. In the cycle the measurement ends, `result_o` takes the count, `done_o` rises and `busy_o` falls. `result_o` keeps its previous value while busy.
- R8: A `start_i` pulse while busy is ignored. The running measurement keeps its mode, its gate code and its length.
- R9: An accepted start clears `done_o`. `done_o` otherwise stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse every millisecond |
| sig_i | input | 1 | Asynchronous input measured in frequency mode |
| lf_sig_i | input | 1 | Asynchronous low-frequency input measured in period mode |
| mode_i | input | 1 | 0 = frequency, 1 = period; captured at start |
| gate_sel_i | input | 2 | Gate length code; captured at start |
| start_i | input | 1 | Start request, accepted only while idle |
| busy_o | output | 1 | Measurement in progress |
| done_o | output | 1 | Measurement finished; cleared by an accepted start |
| ovf_o | output | 1 | Sticky saturation flag |
| result_o | output | CNT_W | Result of the last finished measurement |

## Verification
Frequency mode is driven with input periods of 10, 25 and 50 cycles, and with a flat input, against all four gate codes. The edges are placed away from the tick boundaries, so the count depends only on the gate length and the edge rate. This separates a wrong gate length from a wrong edge count. Period mode is driven with low-frequency periods from 12 to 1000 cycles while the high-speed input toggles at a different rate, which shows which input each mode reads. A narrow-counter instance is run at periods of exactly 2^W − 1 and 2^W cycles, with a normal run after them. This separates saturation without overflow from true overflow and checks that the flag is cleared.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } mc_state_e;

    typedef enum logic {
        MODE_FREQ   = 1'b0,
        MODE_PERIOD = 1'b1
    } mc_mode_e;

endpackage

// File: rtl/mc_edge_sync.sv
module mc_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    // sh[0..STAGES-1] synchronize, sh[STAGES] holds the previous synchronized value
    localparam int unsigned SW = STAGES + 1;

    logic [SW-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SW-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/mc_gate_timer.sv
module mc_gate_timer #(
    parameter int unsigned GATE0 = 1,
    parameter int unsigned GATE1 = 4,
    parameter int unsigned GATE2 = 8,
    parameter int unsigned GATE3 = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       run_i,
    input  logic       tick_i,
    input  logic [1:0] sel_i,
    output logic       close_o
);
    localparam int unsigned MAX01 = (GATE0 > GATE1) ? GATE0 : GATE1;
    localparam int unsigned MAX23 = (GATE2 > GATE3) ? GATE2 : GATE3;
    localparam int unsigned GMAX  = (MAX01 > MAX23) ? MAX01 : MAX23;
    localparam int unsigned TW    = $clog2(GMAX + 1);
    localparam int unsigned GATES [4] = '{GATE0, GATE1, GATE2, GATE3};

    logic [TW-1:0] cnt_d, cnt_q;
    logic [TW-1:0] last_tick;

    always_comb begin
        last_tick = TW'(GATES[sel_i] - 1);
        close_o   = run_i & tick_i & (cnt_q == last_tick);
        cnt_d     = cnt_q;
        if (clr_i)               cnt_d = '0;
        else if (run_i & tick_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/mc_sat_counter.sv
module mc_sat_counter #(
    parameter int unsigned W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] nxt_o,
    output logic         ovf_o
);
    localparam logic [W-1:0] TOP = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         ovf;
    } cnt_t;

    cnt_t n_d, n_q;

    always_comb begin
        n_d = n_q;
        if (clr_i) begin
            n_d.cnt = '0;
            n_d.ovf = 1'b0;
        end else if (inc_i) begin
            if (n_q.cnt == TOP) n_d.ovf = 1'b1;
            else                n_d.cnt = n_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) n_q <= '0;
        else        n_q <= n_d;
    end

    assign nxt_o = n_d.cnt;
    assign ovf_o = n_q.ovf;

endmodule

// File: rtl/gated_freq_counter.sv
module gated_freq_counter #(
    parameter int unsigned CNT_W       = 20,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned GATE0       = 1,
    parameter int unsigned GATE1       = 4,
    parameter int unsigned GATE2       = 8,
    parameter int unsigned GATE3       = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             sig_i,
    input  logic             lf_sig_i,
    input  logic             mode_i,
    input  logic [1:0]       gate_sel_i,
    input  logic             start_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             ovf_o,
    output logic [CNT_W-1:0] result_o
);
    import mc_pkg::*;

    typedef struct packed {
        mc_state_e        state;
        mc_mode_e         mode;
        logic [1:0]       sel;
        logic             done;
        logic [CNT_W-1:0] result;
    } regs_t;

    regs_t r_d, r_q;

    logic             hf_rise, lf_rise;
    logic             gate_close;
    logic             start_ok;
    logic             cnt_inc;
    logic [CNT_W-1:0] cnt_nxt;
    logic             running_freq, running_period;

    mc_edge_sync #(.STAGES(SYNC_STAGES)) u_hf_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sig_i),
        .rise_o  (hf_rise)
    );

    mc_edge_sync #(.STAGES(SYNC_STAGES)) u_lf_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (lf_sig_i),
        .rise_o  (lf_rise)
    );

    mc_gate_timer #(
        .GATE0 (GATE0),
        .GATE1 (GATE1),
        .GATE2 (GATE2),
        .GATE3 (GATE3)
    ) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (start_ok),
        .run_i   (running_freq),
        .tick_i  (tick_i),
        .sel_i   (r_q.sel),
        .close_o (gate_close)
    );

    mc_sat_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (start_ok),
        .inc_i (cnt_inc),
        .nxt_o (cnt_nxt),
        .ovf_o (ovf_o)
    );

    always_comb begin
        start_ok       = (r_q.state == ST_IDLE) & start_i;
        running_freq   = (r_q.state == ST_RUN) & (r_q.mode == MODE_FREQ);
        running_period = (r_q.state == ST_RUN) & (r_q.mode == MODE_PERIOD);
        cnt_inc        = (running_freq & hf_rise) | running_period;
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state = ST_ARM;
                    r_d.mode  = mc_mode_e'(mode_i);
                    r_d.sel   = gate_sel_i;
                    r_d.done  = 1'b0;
                end
            end
            ST_ARM: begin
                if (r_q.mode == MODE_FREQ) begin
                    if (tick_i) r_d.state = ST_RUN;
                end else begin
                    if (lf_rise) r_d.state = ST_RUN;
                end
            end
            ST_RUN: begin
                if ((running_freq & gate_close) | (running_period & lf_rise)) begin
                    r_d.state  = ST_IDLE;
                    r_d.result = cnt_nxt;
                    r_d.done   = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state  <= ST_IDLE;
            r_q.mode   <= MODE_FREQ;
            r_q.sel    <= '0;
            r_q.done   <= 1'b0;
            r_q.result <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o   = (r_q.state != ST_IDLE);
    assign done_o   = r_q.done;
    assign result_o = r_q.result;

endmodule

// File: rtl/mc_meter_checker.sv
module mc_meter_checker #(
    parameter int unsigned CNT_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             ovf_o,
    input logic [CNT_W-1:0] result_o
);
    localparam logic [CNT_W-1:0] TOP = '1;

    a_r7_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    a_r7_done_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> $stable(result_o));

    a_r9_done_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !done_o);

    a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    a_r6_ovf_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !ovf_o);

    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !(start_i && !busy_o)) |=> ovf_o);

    a_r6_saturated: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done_o) && ovf_o) |-> (result_o == TOP));

endmodule

bind gated_freq_counter mc_meter_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .ovf_o    (ovf_o),
    .result_o (result_o)
);

// File: tb/tb_gated_freq_counter.sv
module tb_gated_freq_counter;

    localparam int TICK_CYC = 50;
    localparam int SMALL_W  = 8;

    typedef struct packed {
        logic       mode;
        logic [1:0] sel;
        int         hf_p;
        int         hf_ph;
        int         lf_p;
        int         exp_cnt;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 2'd0, 10, 3,  7,    5},
        '{1'b0, 2'd1, 25, 8,  7,    8},
        '{1'b0, 2'd2, 50, 20, 7,    8},
        '{1'b0, 2'd3, 10, 3,  7,  160},
        '{1'b0, 2'd2, 10, 3,  7,   40},
        '{1'b1, 2'd0, 10, 3,  37,  37},
        '{1'b1, 2'd3, 25, 8,  100, 100},
        '{1'b1, 2'd1, 50, 20, 12,  12},
        '{1'b1, 2'd2, 10, 3,  1000, 1000},
        '{1'b0, 2'd1, 0,  0,  7,    0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 1'b0;
    logic sig_i = 1'b0;
    logic lf_sig_i = 1'b0;
    logic mode_i = 1'b0;
    logic [1:0] gate_sel_i = 2'd0;
    logic start_i = 1'b0;

    logic        busy_o, done_o, ovf_o;
    logic [19:0] result_o;
    logic        s_busy, s_done, s_ovf;
    logic [SMALL_W-1:0] s_result;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;
    int cyc = 0;
    int hf_p = 0, hf_ph = 0, lf_p = 0;

    always #5 clk = ~clk;

    gated_freq_counter dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sig_i(sig_i), .lf_sig_i(lf_sig_i),
        .mode_i(mode_i), .gate_sel_i(gate_sel_i), .start_i(start_i),
        .busy_o(busy_o), .done_o(done_o), .ovf_o(ovf_o), .result_o(result_o)
    );

    gated_freq_counter #(.CNT_W(SMALL_W)) dut_small (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sig_i(sig_i), .lf_sig_i(lf_sig_i),
        .mode_i(mode_i), .gate_sel_i(gate_sel_i), .start_i(start_i),
        .busy_o(s_busy), .done_o(s_done), .ovf_o(s_ovf), .result_o(s_result)
    );

    // Stimulus patterns: tick every TICK_CYC cycles, inputs as square waves
    always @(negedge clk) begin
        cyc <= cyc + 1;
        tick_i <= (cyc % TICK_CYC) == 0;
        if (hf_p == 0) sig_i <= 1'b0;
        else sig_i <= ((((cyc - hf_ph) % hf_p) + hf_p) % hf_p) < (hf_p / 2);
        if (lf_p == 0) lf_sig_i <= 1'b0;
        else lf_sig_i <= (cyc % lf_p) < (lf_p / 2);
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_start(input logic m, input logic [1:0] s);
        @(negedge clk);
        mode_i = m;
        gate_sel_i = s;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n;
        n = 0;
        while (!done_o && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(req, "finished in time", longint'(done_o), 1);
        chk("R7", "busy low when done", longint'(busy_o), 0);
    endtask

    task automatic set_pat(input int hp, input int hph, input int lp);
        hf_p = hp;
        hf_ph = hph;
        lf_p = lp;
        repeat (60) @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        chk("R1", "busy in reset", longint'(busy_o), 0);
        chk("R1", "done in reset", longint'(done_o), 0);
        chk("R1", "ovf in reset", longint'(ovf_o), 0);
        chk("R1", "result in reset", longint'(result_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy after reset", longint'(busy_o), 0);
        chk("R1", "result after reset", longint'(result_o), 0);

        // Table walk: frequency (R2, R3, R5) and period (R4, R5)
        for (int i = 0; i < NVEC; i++) begin
            set_pat(VECS[i].hf_p, VECS[i].hf_ph, VECS[i].lf_p);
            do_start(VECS[i].mode, VECS[i].sel);
            chk("R7", "busy after start", longint'(busy_o), 1);
            chk("R9", "done cleared by start", longint'(done_o), 0);
            wait_done(VECS[i].mode ? "R4" : "R2");
            if (VECS[i].mode)
                chk("R4", $sformatf("period vec %0d", i), longint'(result_o), longint'(VECS[i].exp_cnt));
            else
                chk("R3", $sformatf("gate count vec %0d", i), longint'(result_o), longint'(VECS[i].exp_cnt));
            chk("R5", "no overflow", longint'(ovf_o), 0);
        end

        // R8 and R7: start while busy ignored, result held during the run
        set_pat(10, 3, 7);
        do_start(1'b0, 2'd1);
        repeat (60) @(negedge clk);
        chk("R7", "result held while busy", longint'(result_o), 0);
        do_start(1'b1, 2'd3);
        chk("R8", "still busy after ignored start", longint'(busy_o), 1);
        wait_done("R8");
        chk("R8", "mode and gate kept", longint'(result_o), 20);
        repeat (20) @(negedge clk);
        chk("R9", "done stays set", longint'(done_o), 1);

        // R6: saturation boundary on the narrow instance
        set_pat(10, 3, 255);
        do_start(1'b1, 2'd0);
        wait_done("R6");
        chk("R6", "exact max value", longint'(s_result), 255);
        chk("R6", "exact max no ovf", longint'(s_ovf), 0);

        set_pat(10, 3, 256);
        do_start(1'b1, 2'd0);
        wait_done("R6");
        chk("R6", "saturated result", longint'(s_result), 255);
        chk("R6", "ovf set", longint'(s_ovf), 1);
        chk("R6", "wide instance unsaturated", longint'(result_o), 256);
        chk("R6", "wide instance no ovf", longint'(ovf_o), 0);
        repeat (30) @(negedge clk);
        chk("R6", "ovf sticky", longint'(s_ovf), 1);

        set_pat(10, 3, 40);
        do_start(1'b1, 2'd0);
        chk("R6", "ovf cleared by start", longint'(s_ovf), 0);
        wait_done("R6");
        chk("R6", "result after clear", longint'(s_result), 40);
        chk("R6", "ovf stays clear", longint'(s_ovf), 0);

        if (!finished) begin
            finished = 1;
            summary();
            $finish;
        end
    end

endmodule